// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block is the control section of a horizontally microcoded processor. It keeps a microaddress register and a microinstruction register. Its control store is a 512-word by 36-bit ROM whose contents are computed in the code. Every clock it presents the fields of the current microinstruction as datapath control lines. In the same cycle it forms the address of the next microinstruction from the stored next-address field, two latched ALU flags and the opcode byte held in the datapath's memory buffer.

The next address is never produced by an adder. A condition result can only set the top address bit. An opcode dispatch can only OR the buffer byte into the low eight bits. Execution in the datapath lies outside the block. The block sees only the negative and zero flags and the 8-bit buffer byte.

Top module: `useq_core`

## Requirements
- R1: While `rst` is high at a clock edge, the microaddress becomes 0 and the microinstruction register becomes all-zero. As a result, `alu_ctl_o`, `c_wr_o` and the three memory strobes read 0.
- R2: A word has 36 bits. From bit 35 downward it holds: next address [35:27], dispatch-enable (jmpc) [26], jump-on-negative (jamn) [25], jump-on-zero (jamz) [24], ALU/shift control [23:16], register write mask [15:7], memory write [6], memory read [5], opcode fetch [4] and B source code [3:0]. Each control output copies its field.
- R3: ROM word 0 has jmpc=1, jamz=1 and every other field 0. A word at address a in 1..255 has next address {0, ~a[7:0]}, jamn=a[1] and jamz=a[0]. A word at address a in 256..511 has next address 0 and no jam bits. For all a≠0: ALU field = a[7:0], write mask = a, {write,read,fetch} = a[2:0], and B code = a[3:0].
- R4: Each clock edge loads the microaddress and the word stored at that address together. The outputs then show that word for the whole following cycle.
- R5: Bit 8 of the next address is next-address bit 8 OR (jamz AND latched Z) OR (jamn AND latched N). A flag whose jam bit is clear has no effect.
- R6: When jmpc is set, bits 7:0 of the next address are the next-address field's bits 7:0 ORed with `mbr_i`, sampled in the same cycle.
- R7: N and Z are registered at each edge. The microinstruction shown after that edge uses the registered values, not the live inputs.
- R8: B codes 0..N_BSRC-1 (default 9) drive exactly the matching bit of `b_oe_o`. Codes at or above N_BSRC drive no bit.
- R9: With every jam bit clear, the next microaddress equals the next-address field exactly, with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbr_i | input | 8 | Opcode byte from the memory buffer |
| alu_n_i | input | 1 | ALU negative flag for the current cycle |
| alu_z_i | input | 1 | ALU zero flag for the current cycle |
| mpc_o | output | 9 | Current microaddress |
| alu_ctl_o | output | 8 | ALU and shifter control |
| c_wr_o | output | 9 | Register write mask |
| mem_write_o | output | 1 | Memory word write |
| mem_read_o | output | 1 | Memory word read |
| mem_fetch_o | output | 1 | Opcode byte fetch |
| b_oe_o | output | N_BSRC | One-hot B source output enables |

## Verification
The dispatch word at address 0 sets both jmpc and jamz. As a result, opcode dispatch and the zero-conditioned high bit act on the same next-address computation. The bench holds Z high through the cycle before dispatch. With opcode 0x08 it then expects microaddress 0x108, which shows the OR in the low byte and the forced top bit together. A separate run toggles Z cycle by cycle to show that the condition uses the registered flag.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 9;
  localparam int ALU_W  = 8;
  localparam int C_W    = 9;
  localparam int B_W    = 4;
  localparam int MBR_W  = 8;
  localparam int WORD_W = ADDR_W + 3 + ALU_W + C_W + 3 + B_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              jmpc;
    logic              jamn;
    logic              jamz;
    logic [ALU_W-1:0]  alu;
    logic [C_W-1:0]    cwr;
    logic              mwrite;
    logic              mread;
    logic              mfetch;
    logic [B_W-1:0]    bsel;
  } uinstr_t;

  // Microprogram contents, computed per address.
  function automatic uinstr_t rom_word(input logic [ADDR_W-1:0] a);
    uinstr_t w;
    w = '0;
    if (a == '0) begin
      w.jmpc = 1'b1;
      w.jamz = 1'b1;
    end else begin
      w.alu = a[ALU_W-1:0];
      w.cwr = a;
      {w.mwrite, w.mread, w.mfetch} = a[2:0];
      w.bsel = a[B_W-1:0];
      if (!a[ADDR_W-1]) begin
        w.addr = {1'b0, ~a[ADDR_W-2:0]};
        w.jamn = a[1];
        w.jamz = a[0];
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output uinstr_t           mir
);
  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(ADDR_W'(i));
  end

  // Registered read port doubles as the microinstruction register.
  always_ff @(posedge clk) begin
    if (rst) mir <= '0;
    else     mir <= uinstr_t'(mem[rd_addr]);
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  uinstr_t           mir,
  input  logic              n_q,
  input  logic              z_q,
  input  logic [MBR_W-1:0]  mbr,
  output logic [ADDR_W-1:0] nxt
);
  logic              hi_bit;
  logic [MBR_W-1:0]  low_or;

  always_comb begin
    hi_bit = (mir.jamz & z_q) | (mir.jamn & n_q);
    low_or = mir.jmpc ? mbr : '0;
    nxt    = mir.addr;
    nxt[ADDR_W-1]  = mir.addr[ADDR_W-1] | hi_bit;
    nxt[MBR_W-1:0] = mir.addr[MBR_W-1:0] | low_or;
  end
endmodule

// File: rtl/useq_bdec.sv
module useq_bdec
  import useq_pkg::*;
#(
  parameter int N_SRC = 9
) (
  input  logic [B_W-1:0]   code,
  output logic [N_SRC-1:0] oe
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign oe[g] = (code == B_W'(g));
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int N_BSRC = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MBR_W-1:0]  mbr_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  output logic [ADDR_W-1:0] mpc_o,
  output logic [ALU_W-1:0]  alu_ctl_o,
  output logic [C_W-1:0]    c_wr_o,
  output logic              mem_write_o,
  output logic              mem_read_o,
  output logic              mem_fetch_o,
  output logic [N_BSRC-1:0] b_oe_o
);
  uinstr_t           mir;
  logic [ADDR_W-1:0] mpc_q;
  logic [ADDR_W-1:0] nxt;
  logic              n_q, z_q;

  useq_next u_next (
    .mir (mir),
    .n_q (n_q),
    .z_q (z_q),
    .mbr (mbr_i),
    .nxt (nxt)
  );

  useq_store u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (nxt),
    .mir     (mir)
  );

  useq_bdec #(.N_SRC(N_BSRC)) u_bdec (
    .code (mir.bsel),
    .oe   (b_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mpc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      mpc_q <= nxt;
      n_q   <= alu_n_i;
      z_q   <= alu_z_i;
    end
  end

  assign mpc_o       = mpc_q;
  assign alu_ctl_o   = mir.alu;
  assign c_wr_o      = mir.cwr;
  assign mem_write_o = mir.mwrite;
  assign mem_read_o  = mir.mread;
  assign mem_fetch_o = mir.mfetch;
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk
  import useq_pkg::*;
#(
  parameter int N_SRC = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [MBR_W-1:0]  mbr,
  input logic [ADDR_W-1:0] mpc,
  input uinstr_t           mir,
  input logic              nq,
  input logic              zq,
  input logic [N_SRC-1:0]  boe,
  input logic [C_W-1:0]    cwr,
  input logic [2:0]        memops
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst_q |-> (mpc == '0 && cwr == '0 && memops == 3'b000)); // R1

  AST_MIR_FROM_ROM: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> (mir == rom_word(mpc))); // R4

  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    mir.addr[ADDR_W-1] |=> mpc[ADDR_W-1]); // R5

  AST_COND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ((mir.jamz && zq) || (mir.jamn && nq)) |=> mpc[ADDR_W-1]); // R5

  AST_DISPATCH_OR: assert property (@(posedge clk) disable iff (rst)
    mir.jmpc |=> (mpc[MBR_W-1:0] == ($past(mir.addr[MBR_W-1:0]) | $past(mbr)))); // R6

  AST_PLAIN_JUMP: assert property (@(posedge clk) disable iff (rst)
    (!mir.jmpc && !mir.jamn && !mir.jamz) |=> (mpc == $past(mir.addr))); // R9

  AST_BSRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(boe)); // R8
endmodule

bind useq_core useq_core_chk #(.N_SRC(N_BSRC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mbr    (mbr_i),
  .mpc    (mpc_o),
  .mir    (mir),
  .nq     (n_q),
  .zq     (z_q),
  .boe    (b_oe_o),
  .cwr    (c_wr_o),
  .memops ({mem_write_o, mem_read_o, mem_fetch_o})
);

// File: tb/useq_core_test.sv
module useq_core_test;
  localparam int CLK_NS = 10;
  localparam int NB     = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mbr = '0;
  logic       nf = 1'b0, zf = 1'b0;
  logic [8:0] mpc;
  logic [7:0] alu;
  logic [8:0] cwr;
  logic       mw, mr, mf;
  logic [NB-1:0] boe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  useq_core #(.N_BSRC(NB)) uut (
    .clk(clk), .rst(rst), .mbr_i(mbr), .alu_n_i(nf), .alu_z_i(zf),
    .mpc_o(mpc), .alu_ctl_o(alu), .c_wr_o(cwr),
    .mem_write_o(mw), .mem_read_o(mr), .mem_fetch_o(mf), .b_oe_o(boe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Compares the microaddress, then the field outputs expected for that address.
  task automatic check_at(input string req, input logic [8:0] a);
    logic [7:0]    e_alu;
    logic [8:0]    e_c;
    logic [2:0]    e_mem;
    logic [NB-1:0] e_boe;
    checks++;
    if (mpc !== a) begin
      fails++;
      $display("FAIL %s: mpc actual %h expected %h", req, mpc, a);
    end
    e_alu = (a == 0) ? 8'h00 : a[7:0];
    e_c   = (a == 0) ? 9'h000 : a;
    e_mem = (a == 0) ? 3'b000 : a[2:0];
    e_boe = (a == 0 || a[3:0] >= NB) ? (a == 0 ? NB'(1) : '0) : (NB'(1) << a[3:0]);
    checks++;
    if ({alu, cwr, mw, mr, mf, boe} !== {e_alu, e_c, e_mem, e_boe}) begin
      fails++;
      $display("FAIL R2 R3 R8 at %h: fields actual %h/%h/%b/%b expected %h/%h/%b/%b",
               a, alu, cwr, {mw, mr, mf}, boe, e_alu, e_c, e_mem, e_boe);
    end
  endtask

  task automatic apply_reset(input logic n, input logic z, input logic [7:0] op);
    rst = 1'b1; nf = n; zf = z; mbr = op;
    tick();
    tick();
    checks++;
    if ({mpc, alu, cwr, mw, mr, mf} !== '0) begin
      fails++;
      $display("FAIL R1: mpc/alu/c/mem actual %h/%h/%h/%b expected all zero",
               mpc, alu, cwr, {mw, mr, mf});
    end
    rst = 1'b0;
  endtask

  task automatic t_reset_then_fetch();
    apply_reset(1'b0, 1'b0, 8'h00);
    tick();
    check_at("R4 dispatch word loaded", 9'h000);
  endtask

  task automatic t_dispatch_plain();
    apply_reset(1'b0, 1'b0, 8'h05);
    tick(); check_at("R4", 9'h000);
    tick(); check_at("R6 dispatch 05", 9'h005);
    tick(); check_at("R5 jamz with Z low", 9'h0FA);
  endtask

  task automatic t_dispatch_high();
    apply_reset(1'b0, 1'b1, 8'h08);
    tick(); check_at("R4", 9'h000);
    tick(); check_at("R6 R5 dispatch with Z forcing top bit, R8 code 8", 9'h108);
    tick(); check_at("R9 plain jump to 0", 9'h000);
  endtask

  task automatic t_flag_latch();
    apply_reset(1'b0, 1'b0, 8'h01);
    tick(); check_at("R4", 9'h000);
    zf = 1'b1;
    tick(); check_at("R7 dispatch used latched Z low", 9'h001);
    zf = 1'b0;
    tick(); check_at("R7 jamz used latched Z high", 9'h1FE);
  endtask

  task automatic t_jamn();
    apply_reset(1'b1, 1'b0, 8'h02);
    tick(); check_at("R4", 9'h000);
    tick(); check_at("R5 N ignored at dispatch", 9'h002);
    tick(); check_at("R5 jamn with N high", 9'h1FD);
    tick(); check_at("R9 plain jump to 0", 9'h000);
  endtask

  task automatic t_no_jam();
    apply_reset(1'b1, 1'b0, 8'h04);
    tick(); check_at("R4", 9'h000);
    tick(); check_at("R6 dispatch 04", 9'h004);
    tick(); check_at("R5 N ignored without jam", 9'h0FB);
  endtask

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset_then_fetch();
    t_dispatch_plain();
    t_dispatch_high();
    t_flag_latch();
    t_jamn();
    t_no_jam();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule